// File: doc/BRIEF.md
# Chained DMA Descriptor Walker

This block is the control front end of a DMA engine. Software loads three 32-bit registers: a table pointer, a data address and a count word. It then pulses a start strobe, with a mode input that picks one of two kinds of run. In direct mode the block hands the current data address, length and function code to a downstream data mover as one transfer request. In table mode it walks a linked list of descriptors in memory. Each descriptor is two consecutive longwords. The block reads them through a request/acknowledge read port, issues the transfer, waits for the mover to report completion and then follows the link flag to the next descriptor.

Each count word carries the transfer length, a 3-bit function code that travels with the request, and a link flag. The flag is honoured only during a table walk. The table pointer keeps no low address bits, so descriptors are always longword aligned. A busy flag covers the whole run, and a single-cycle done pulse closes it. The block does not move data, arbitrate for a bus or handle errors.

Top module: `dma_chain_walker`

## Requirements
- R1: A write to the table pointer (select code 0) stores data bits 31:2 and reads back with bits 1:0 as zero, whatever was written there; no error is signalled.
- R2: Synchronous reset returns `busy`, `done`, `rd_req` and `xfer_valid` to 0 and leaves the table pointer, data address (select 1) and count word (select 2) registers unchanged.
- R3: A start with `table_mode`=0 issues exactly one transfer and performs no descriptor reads. The transfer carries the data address, length = count bits 23:0 and function code = count bits 26:24. Bit 31 (link) is ignored, and so are bits 30:27.
- R4: A start with `table_mode`=1 reads each descriptor as two words: the data address at the entry pointer, then the count word at pointer+4. The first entry pointer is the table pointer.
- R5: During a table walk, a count word with bit 31 set makes the block move on to the entry 8 bytes further on once the transfer completes. A clear bit 31 ends the walk after that entry's transfer completes.
- R6: After a table walk, the data address and count word registers read back the last descriptor's values.
- R7: `xfer_valid` stays high with stable address, length and function code until `xfer_ready` is sampled high. It then drops, and the block waits for `xfer_cmpl` before doing anything else.
- R8: `busy` is high from the cycle after start is sampled until the end of the `done` pulse. `done` is high for exactly one cycle, the cycle after the final `xfer_cmpl` is sampled.
- R9: While `busy` is high, register writes and start strobes are ignored.
- R10: `rd_req` stays high with a stable, longword-aligned `rd_addr` until `rd_ack` is sampled high. Each acknowledge delivers exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register select: 0 table pointer, 1 data address, 2 count word |
| cfg_wr_data | input | 32 | Register write data |
| tbl_addr_o | output | 32 | Table pointer readback |
| data_addr_o | output | 32 | Data address readback |
| byte_cnt_o | output | 32 | Count word readback |
| start | input | 1 | Start strobe |
| table_mode | input | 1 | 1 selects a table walk, 0 a direct transfer |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Descriptor read address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data word |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Data mover accepts the request |
| xfer_addr | output | 32 | Transfer data address |
| xfer_len | output | 24 | Transfer length in bytes |
| xfer_fc | output | 3 | Transfer function code |
| xfer_cmpl | input | 1 | Data mover finished the accepted transfer |

## Verification
Start is sampled at a clock edge E0. After E0, `busy` is high. In the same cycle `xfer_valid` is also high (direct mode) or `rd_req` is high with `rd_addr` equal to the table pointer (table mode). A request is accepted at the edge that samples its ready or acknowledge, so `xfer_valid` is low one cycle later. `done` rises one cycle after the final `xfer_cmpl` is sampled. The bench drives every input on falling edges and reads outputs there, half a cycle after the edge that updated them. It records the completion input at rising edges, so it knows which edge the design saw. Transfer and read-address logs are compared in order, against values derived from the descriptor images the bench placed in memory.

// File: rtl/dma_walk_pkg.sv
package dma_walk_pkg;

    localparam int ADDR_W      = 32;
    localparam int WORD_W      = 32;
    localparam int LEN_W       = 24;
    localparam int FC_W        = 3;
    localparam int ALIGN_BITS  = 2;
    localparam int WORD_BYTES  = 4;
    localparam int ENTRY_WORDS = 2;
    localparam int ENTRY_BYTES = ENTRY_WORDS * WORD_BYTES;
    localparam int RSVD_W      = WORD_W - 1 - FC_W - LEN_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_ADDR,
        ST_FETCH_CNT,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        SEL_TBL  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    // Count word layout: link flag on top, reserved, function code, length.
    typedef struct packed {
        logic              link;
        logic [RSVD_W-1:0] rsvd;
        logic [FC_W-1:0]   fc;
        logic [LEN_W-1:0]  len;
    } cnt_word_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [FC_W-1:0]   fc;
    } xfer_req_t;

    function automatic xfer_req_t make_req(input logic [ADDR_W-1:0] a,
                                           input cnt_word_t c);
        xfer_req_t r;
        r.addr = a;
        r.len  = c.len;
        r.fc   = c.fc;
        return r;
    endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_walk_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = WORD_W,
    parameter int ALIGN = ALIGN_BITS
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_block,
    input  logic          ld_data,
    input  logic          ld_cnt,
    input  logic [DW-1:0] ld_word,
    output logic [AW-1:0] tbl_q,
    output logic [AW-1:0] data_q,
    output logic [DW-1:0] cnt_q
);
    // No reset on any of these: contents survive a reset by design.
    logic [AW-1:ALIGN] tbl_hi;
    logic              wr_ok;

    assign wr_ok = wr_en && !wr_block;

    always_ff @(posedge clk) begin
        if (wr_ok && (wr_sel == SEL_TBL))
            tbl_hi <= wr_data[AW-1:ALIGN];
    end

    assign tbl_q = {tbl_hi, {ALIGN{1'b0}}};

    always_ff @(posedge clk) begin
        if (ld_data)
            data_q <= ld_word[AW-1:0];
        else if (wr_ok && (wr_sel == SEL_DATA))
            data_q <= wr_data[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (ld_cnt)
            cnt_q <= ld_word;
        else if (wr_ok && (wr_sel == SEL_CNT))
            cnt_q <= wr_data;
    end

endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
    import dma_walk_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int ENTRY_B   = ENTRY_BYTES,
    parameter int WORD_B    = WORD_BYTES
) (
    input  logic          clk,
    input  logic          load_base,
    input  logic [AW-1:0] base,
    input  logic          advance,
    input  logic          second_word,
    output logic [AW-1:0] rd_addr
);
    localparam logic [AW-1:0] STEP_ENTRY = AW'(ENTRY_B);
    localparam logic [AW-1:0] STEP_WORD  = AW'(WORD_B);

    logic [AW-1:0] entry_ptr;

    always_ff @(posedge clk) begin
        if (load_base)
            entry_ptr <= base;
        else if (advance)
            entry_ptr <= entry_ptr + STEP_ENTRY;
    end

    assign rd_addr = second_word ? (entry_ptr + STEP_WORD) : entry_ptr;

endmodule

// File: rtl/dma_walk_fsm.sv
module dma_walk_fsm
    import dma_walk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic table_mode,
    input  logic link_flag,
    input  logic rd_ack,
    input  logic xfer_ready,
    input  logic xfer_cmpl,
    output logic busy,
    output logic done,
    output logic rd_req,
    output logic second_word,
    output logic load_base,
    output logic advance,
    output logic ld_data,
    output logic ld_cnt,
    output logic xfer_valid
);
    walk_state_e state_q, state_d;
    logic        walk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            walk_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start)
                walk_q <= table_mode;
        end
    end

    always_comb begin
        state_d     = state_q;
        rd_req      = 1'b0;
        second_word = 1'b0;
        load_base   = 1'b0;
        advance     = 1'b0;
        ld_data     = 1'b0;
        ld_cnt      = 1'b0;
        xfer_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load_base = table_mode;
                    state_d   = table_mode ? ST_FETCH_ADDR : ST_ISSUE;
                end
            end
            ST_FETCH_ADDR: begin
                rd_req = 1'b1;
                if (rd_ack) begin
                    ld_data = 1'b1;
                    state_d = ST_FETCH_CNT;
                end
            end
            ST_FETCH_CNT: begin
                rd_req      = 1'b1;
                second_word = 1'b1;
                if (rd_ack) begin
                    ld_cnt  = 1'b1;
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                xfer_valid = 1'b1;
                if (xfer_ready)
                    state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (xfer_cmpl) begin
                    if (walk_q && link_flag) begin
                        advance = 1'b1;
                        state_d = ST_FETCH_ADDR;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);

endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
    import dma_walk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_sel,
    input  logic [WORD_W-1:0] cfg_wr_data,
    output logic [ADDR_W-1:0] tbl_addr_o,
    output logic [ADDR_W-1:0] data_addr_o,
    output logic [WORD_W-1:0] byte_cnt_o,
    input  logic              start,
    input  logic              table_mode,
    output logic              busy,
    output logic              done,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    output logic [FC_W-1:0]   xfer_fc,
    input  logic              xfer_cmpl
);
    logic      second_word, load_base, advance, ld_data, ld_cnt;
    cnt_word_t cnt_f;
    xfer_req_t req;

    dma_cfg_regs #(
        .AW    (ADDR_W),
        .DW    (WORD_W),
        .ALIGN (ALIGN_BITS)
    ) u_regs (
        .clk      (clk),
        .wr_en    (cfg_wr_en),
        .wr_sel   (cfg_wr_sel),
        .wr_data  (cfg_wr_data),
        .wr_block (busy),
        .ld_data  (ld_data),
        .ld_cnt   (ld_cnt),
        .ld_word  (rd_data),
        .tbl_q    (tbl_addr_o),
        .data_q   (data_addr_o),
        .cnt_q    (byte_cnt_o)
    );

    dma_desc_fetch #(
        .AW      (ADDR_W),
        .ENTRY_B (ENTRY_BYTES),
        .WORD_B  (WORD_BYTES)
    ) u_fetch (
        .clk         (clk),
        .load_base   (load_base),
        .base        (tbl_addr_o),
        .advance     (advance),
        .second_word (second_word),
        .rd_addr     (rd_addr)
    );

    assign cnt_f = cnt_word_t'(byte_cnt_o);

    dma_walk_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .table_mode  (table_mode),
        .link_flag   (cnt_f.link),
        .rd_ack      (rd_ack),
        .xfer_ready  (xfer_ready),
        .xfer_cmpl   (xfer_cmpl),
        .busy        (busy),
        .done        (done),
        .rd_req      (rd_req),
        .second_word (second_word),
        .load_base   (load_base),
        .advance     (advance),
        .ld_data     (ld_data),
        .ld_cnt      (ld_cnt),
        .xfer_valid  (xfer_valid)
    );

    assign req       = make_req(data_addr_o, cnt_f);
    assign xfer_addr = req.addr;
    assign xfer_len  = req.len;
    assign xfer_fc   = req.fc;

endmodule

// File: rtl/dma_chain_walker_chk.sv
module dma_chain_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr_en,
    input logic [1:0]  cfg_wr_sel,
    input logic [31:0] cfg_wr_data,
    input logic [31:0] tbl_addr_o,
    input logic        busy,
    input logic        done,
    input logic        rd_req,
    input logic        rd_ack,
    input logic [31:0] rd_addr,
    input logic        xfer_valid,
    input logic        xfer_ready,
    input logic [31:0] xfer_addr,
    input logic [23:0] xfer_len,
    input logic [2:0]  xfer_fc
);
    a_r1_tbl_write_masked: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_wr_sel == 2'd0 && !busy)
        |=> tbl_addr_o == {$past(cfg_wr_data[31:2]), 2'b00});

    a_r2_reset_quiet: assert property (@(posedge clk)
        rst |=> (!busy && !done && !rd_req && !xfer_valid));

    a_r7_xfer_hold: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !xfer_ready)
        |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_len) && $stable(xfer_fc)));

    a_r7_xfer_drop: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && xfer_ready) |=> !xfer_valid);

    a_r8_done_inside_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    a_r9_tbl_kept_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_wr_en) |=> $stable(tbl_addr_o));

    a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    a_r10_rd_aligned: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr[1:0] == 2'b00));

    a_r10_one_port: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && xfer_valid));

endmodule

bind dma_chain_walker dma_chain_walker_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_sel  (cfg_wr_sel),
    .cfg_wr_data (cfg_wr_data),
    .tbl_addr_o  (tbl_addr_o),
    .busy        (busy),
    .done        (done),
    .rd_req      (rd_req),
    .rd_ack      (rd_ack),
    .rd_addr     (rd_addr),
    .xfer_valid  (xfer_valid),
    .xfer_ready  (xfer_ready),
    .xfer_addr   (xfer_addr),
    .xfer_len    (xfer_len),
    .xfer_fc     (xfer_fc)
);

// File: tb/dma_chain_walker_tb.sv
module dma_chain_walker_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en;
    logic [1:0]  cfg_wr_sel;
    logic [31:0] cfg_wr_data;
    logic [31:0] tbl_addr_o, data_addr_o, byte_cnt_o;
    logic        start, table_mode, busy, done;
    logic        rd_req, rd_ack;
    logic [31:0] rd_addr, rd_data;
    logic        xfer_valid, xfer_ready, xfer_cmpl;
    logic [31:0] xfer_addr;
    logic [23:0] xfer_len;
    logic [2:0]  xfer_fc;

    always #2 clk = ~clk;

    dma_chain_walker u_dut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .tbl_addr_o(tbl_addr_o), .data_addr_o(data_addr_o),
        .byte_cnt_o(byte_cnt_o), .start(start), .table_mode(table_mode), .busy(busy),
        .done(done), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
        .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_fc(xfer_fc),
        .xfer_cmpl(xfer_cmpl)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] mem [64];
    logic [31:0] rd_log [32];
    logic [31:0] xa_log [16];
    logic [23:0] xl_log [16];
    logic [2:0]  xf_log [16];
    int nr = 0;
    int nx = 0;
    logic cmpl_seen = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Descriptor memory: one word per acknowledge, ack for one cycle.
    initial begin
        rd_ack = 1'b0;
        rd_data = '0;
        forever begin
            @(negedge clk);
            if (rd_ack) rd_ack = 1'b0;
            else if (rd_req && !rst) begin
                rd_ack = 1'b1;
                rd_data = mem[rd_addr[7:2]];
                if (nr < 32) rd_log[nr] = rd_addr;
                nr++;
            end
        end
    end

    // Data mover: ready one cycle after valid, completion a few cycles later.
    initial begin
        bit pend;
        int wait_n;
        pend = 0;
        wait_n = 0;
        xfer_ready = 1'b0;
        xfer_cmpl = 1'b0;
        forever begin
            @(negedge clk);
            xfer_cmpl = 1'b0;
            if (pend) begin
                if (wait_n == 0) begin xfer_cmpl = 1'b1; pend = 0; end
                else wait_n--;
            end
            if (xfer_ready) begin
                xfer_ready = 1'b0;
                pend = 1;
                wait_n = 2;
            end else if (xfer_valid && !rst) begin
                xfer_ready = 1'b1;
                if (nx < 16) begin
                    xa_log[nx] = xfer_addr;
                    xl_log[nx] = xfer_len;
                    xf_log[nx] = xfer_fc;
                end
                nx++;
            end
        end
    end

    always @(posedge clk) cmpl_seen <= xfer_cmpl;

    // Done timing monitor (R8)
    always @(negedge clk) begin
        if (!rst && done) begin
            chk("R8 done follows sampled cmpl", {31'd0, cmpl_seen}, 32'd1);
            chk("R8 busy during done", {31'd0, busy}, 32'd1);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_sel = sel;
        cfg_wr_data = val;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        cfg_wr_sel = 2'd3;
    endtask

    task automatic run(input logic mode, input logic [31:0] first_rd);
        nr = 0;
        nx = 0;
        @(negedge clk);
        start = 1'b1;
        table_mode = mode;
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after start", {31'd0, busy}, 32'd1);
        if (mode) begin
            chk("R4 first read request", {31'd0, rd_req}, 32'd1);
            chk("R4 first read address", rd_addr, first_rd);
        end else begin
            chk("R3 direct request valid", {31'd0, xfer_valid}, 32'd1);
        end
    endtask

    task automatic wait_done();
        int k;
        k = 0;
        while (!done && k < 2000) begin
            @(negedge clk);
            k++;
        end
        @(negedge clk);
        chk("R8 done one cycle", {31'd0, done}, 32'd0);
        chk("R8 idle after done", {31'd0, busy}, 32'd0);
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] cnt;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{32'h1000_0000, 32'h0000_0010},
        '{32'hFFFF_FFFC, 32'h07FF_FFFF},
        '{32'h0000_0004, 32'h8300_0001},
        '{32'hABCD_0120, 32'hFCAB_CDEF}
    };

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        // chain at 0x40: three entries
        mem[16] = 32'h2000_0000; mem[17] = 32'h8100_0100;
        mem[18] = 32'h2000_1000; mem[19] = 32'h8200_0020;
        mem[20] = 32'h2000_2000; mem[21] = 32'h0500_0003;
        // single entry at 0x80
        mem[32] = 32'h3000_0000; mem[33] = 32'h0600_0008;

        rst = 1'b1;
        cfg_wr_en = 1'b0;
        cfg_wr_sel = 2'd3;
        cfg_wr_data = '0;
        start = 1'b0;
        table_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 busy in reset", {31'd0, busy}, 32'd0);
        chk("R2 done in reset", {31'd0, done}, 32'd0);
        chk("R2 rd_req in reset", {31'd0, rd_req}, 32'd0);
        chk("R2 xfer_valid in reset", {31'd0, xfer_valid}, 32'd0);
        rst = 1'b0;

        // Direct-mode vectors (R3, R7)
        for (int v = 0; v < 4; v++) begin
            write_reg(2'd1, VEC[v].addr);
            write_reg(2'd2, VEC[v].cnt);
            run(1'b0, 32'h0);
            @(negedge clk);
            chk("R7 valid drops after accept", {31'd0, xfer_valid}, 32'd0);
            chk("R7 waits for completion", {31'd0, busy}, 32'd1);
            wait_done();
            chk("R3 one transfer", nx, 1);
            chk("R3 no descriptor reads", nr, 0);
            chk("R3 address", xa_log[0], VEC[v].addr);
            chk("R3 length bits 23:0", {8'd0, xl_log[0]}, {8'd0, VEC[v].cnt[23:0]});
            chk("R3 fc bits 26:24", {29'd0, xf_log[0]}, {29'd0, VEC[v].cnt[26:24]});
        end

        // R1: low pointer bits dropped
        write_reg(2'd0, 32'h0000_0043);
        chk("R1 table pointer low bits", tbl_addr_o, 32'h0000_0040);

        // Three-entry chain, with writes and start during busy (R9)
        run(1'b1, 32'h0000_0040);
        write_reg(2'd0, 32'h0000_0100);
        @(negedge clk);
        start = 1'b1;
        table_mode = 1'b0;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R9 pointer write ignored", tbl_addr_o, 32'h0000_0040);
        chk("R9 start ignored", nx, 3);
        chk("R4 read count", nr, 6);
        for (int i = 0; i < 6; i++)
            chk("R4 read order", rd_log[i], 32'h40 + 32'(4 * i));
        for (int i = 0; i < 3; i++) begin
            chk("R5 entry address", xa_log[i], mem[16 + 2 * i]);
            chk("R5 entry length", {8'd0, xl_log[i]}, {8'd0, mem[17 + 2 * i][23:0]});
            chk("R5 entry fc", {29'd0, xf_log[i]}, {29'd0, mem[17 + 2 * i][26:24]});
        end
        chk("R6 data address shows last", data_addr_o, 32'h2000_2000);
        chk("R6 count word shows last", byte_cnt_o, 32'h0500_0003);

        // Single-entry table (R5 end-of-chain)
        write_reg(2'd0, 32'h0000_0080);
        run(1'b1, 32'h0000_0080);
        wait_done();
        chk("R5 single entry transfer count", nx, 1);
        chk("R4 single entry reads", nr, 2);
        chk("R4 second word address", rd_log[1], 32'h0000_0084);
        chk("R5 single entry length", {8'd0, xl_log[0]}, 32'h8);
        chk("R6 data after single", data_addr_o, 32'h3000_0000);

        // R2: reset keeps register contents
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R2 table pointer kept", tbl_addr_o, 32'h0000_0080);
        chk("R2 data address kept", data_addr_o, 32'h3000_0000);
        chk("R2 count word kept", byte_cnt_o, 32'h0600_0008);

        // R2: reset in mid-walk stops the block
        write_reg(2'd0, 32'h0000_0040);
        run(1'b1, 32'h0000_0040);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R2 busy cleared mid-walk", {31'd0, busy}, 32'd0);
        chk("R2 rd_req cleared mid-walk", {31'd0, rd_req}, 32'd0);
        chk("R2 xfer_valid cleared mid-walk", {31'd0, xfer_valid}, 32'd0);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        chk("R2 stays idle after reset", {31'd0, busy}, 32'd0);
        chk("R2 pointer kept after mid-walk reset", tbl_addr_o, 32'h0000_0040);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule